// File: doc/BRIEF.md
# Stack Pointer Transfer Unit

This block keeps the 16-bit stack pointer of a small 8-bit processor. It handles the byte-wise push and pop steps and a single "reset stack pointer" command. The decoder supplies a command strobe, push and pop strobes, the eight processor status flags, the interrupt (I) bit and the current contents of the register pair R1:R0. The block returns the stack pointer and a write-back value for R1:R0 with an enable.

Build-time parameters choose how the command behaves. In fixed mode it restores a start address. In transfer mode, one chosen status flag sets the direction. When that flag is set, R1:R0 is loaded into the pointer. When it is clear, the pointer is copied out to R1:R0. A supervisor option limits the command to code that runs with the I bit set, and it tells the rest of the core to leave reset with I set.

Top module: `sp_xfer_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `START_ADDR` into the stack pointer and deasserts `rp_wr_en`.
- R2: A push strobe alone decrements the pointer by one at the next edge. 16'h0000 wraps to 16'hFFFF.
- R3: A pop strobe alone increments the pointer by one at the next edge. 16'hFFFF wraps to 16'h0000.
- R4: Push and pop together, with no accepted command, leave the pointer unchanged.
- R5: With `XFER_EN` = 0, an accepted command reloads `START_ADDR` whatever the flags and R1:R0 hold, and never asserts `rp_wr_en`.
- R6: With `XFER_EN` = 1 and the selected flag at 1, an accepted command loads the pointer with {R1,R0}. R1 is bits 15:8 and R0 is bits 7:0.
- R7: With `XFER_EN` = 1 and the selected flag at 0, an accepted command leaves the pointer unchanged. At the next edge it presents the pointer on `r1_out` (bits 15:8) and `r0_out` (bits 7:0), and `rp_wr_en` is high for exactly that one cycle.
- R8: Only flag bit `DIR_FLAG_SEL` (default 4) steers the direction. The other seven flag bits have no effect.
- R9: With `SUPERVISOR` = 1, a command while `ibit` = 0 changes neither the pointer nor the write-back. Push and pop in the same cycle still act.
- R10: `ibit_rst_val` equals `SUPERVISOR`, so the I bit comes out of reset set exactly when supervisor mode is built in.
- R11: An accepted command takes precedence over push and pop in the same cycle. Those strobes are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 1 | Reset-stack-pointer command strobe |
| push | input | 1 | Push one byte (decrement) |
| pop | input | 1 | Pop one byte (increment) |
| flags | input | 8 | Processor status flags |
| ibit | input | 1 | Current interrupt (I) bit |
| r1_in | input | 8 | Current R1 (high byte) |
| r0_in | input | 8 | Current R0 (low byte) |
| sp_out | output | 16 | Stack pointer |
| rp_wr_en | output | 1 | Write-back enable for R1:R0 |
| r1_out | output | 8 | Write-back high byte |
| r0_out | output | 8 | Write-back low byte |
| ibit_rst_val | output | 1 | Reset value the core must give the I bit |

## Verification
The pointer and the write-back are both registered, so every result is due at the first rising edge after its stimulus. The bench drives each stimulus on a falling edge, waits for one rising edge, and samples on the following falling edge before it applies the next vector. In a copy cycle it compares the write-back pair against the pointer it expects, and it confirms that the enable is low again on the next vector. `ibit_rst_val` is a static output and is checked directly on both built variants.

// File: rtl/sp_xfer_unit.sv
module sp_xfer_unit #(
  parameter logic [15:0] START_ADDR   = 16'h03FF,
  parameter bit          XFER_EN      = 1'b1,
  parameter int unsigned DIR_FLAG_SEL = 4,
  parameter bit          SUPERVISOR   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd,
  input  logic        push,
  input  logic        pop,
  input  logic [7:0]  flags,
  input  logic        ibit,
  input  logic [7:0]  r1_in,
  input  logic [7:0]  r0_in,
  output logic [15:0] sp_out,
  output logic        rp_wr_en,
  output logic [7:0]  r1_out,
  output logic [7:0]  r0_out,
  output logic        ibit_rst_val
);
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL = SEL_W'(DIR_FLAG_SEL);

  logic [15:0] sp_q;
  logic [15:0] wb_q;
  logic        we_q;
  logic        cmd_ok, do_load, do_copy, do_restore;

  assign cmd_ok       = cmd && (!SUPERVISOR || ibit);
  assign ibit_rst_val = SUPERVISOR;

  generate
    if (XFER_EN) begin : g_xfer
      assign do_load    = cmd_ok &&  flags[SEL];
      assign do_copy    = cmd_ok && !flags[SEL];
      assign do_restore = 1'b0;
    end else begin : g_fixed
      assign do_load    = 1'b0;
      assign do_copy    = 1'b0;
      assign do_restore = cmd_ok;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= START_ADDR;
      we_q <= 1'b0;
      wb_q <= '0;
    end else begin
      we_q <= do_copy;
      if (do_copy) wb_q <= sp_q;
      if (do_load)             sp_q <= {r1_in, r0_in};
      else if (do_restore)     sp_q <= START_ADDR;
      else if (cmd_ok)         sp_q <= sp_q;
      else if (push && !pop)   sp_q <= sp_q - 16'd1;
      else if (pop && !push)   sp_q <= sp_q + 16'd1;
    end
  end

  assign sp_out   = sp_q;
  assign rp_wr_en = we_q;
  assign r1_out   = wb_q[15:8];
  assign r0_out   = wb_q[7:0];

  p_rst_start_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp_out == START_ADDR && !rp_wr_en));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(push && !pop && !cmd)) |-> sp_out == $past(sp_out) - 16'd1);

  p_pop_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pop && !push && !cmd)) |-> sp_out == $past(sp_out) + 16'd1);

  p_both_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pop && push && !cmd)) |-> $stable(sp_out));

  generate
    if (XFER_EN) begin : g_xfer_chk
      p_load_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd && (ibit || !SUPERVISOR) && flags[SEL]))
          |-> sp_out == $past({r1_in, r0_in}));
      p_copy_out_r7: assert property (@(posedge clk) disable iff (rst)
        rp_wr_en |-> ({r1_out, r0_out} == $past(sp_out) && $stable(sp_out)));
    end else begin : g_fixed_chk
      p_restore_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd && (ibit || !SUPERVISOR))) |-> (sp_out == START_ADDR && !rp_wr_en));
    end
    if (SUPERVISOR) begin : g_sup_chk
      p_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd && !ibit && !push && !pop)) |-> ($stable(sp_out) && !rp_wr_en));
    end
  endgenerate
endmodule

// File: tb/sp_xfer_unit_tb.sv
module sp_xfer_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 16;

  logic clk = 1'b0;
  logic rst, cmd, push, pop, ibit;
  logic [7:0] flags, r1_in, r0_in;
  logic [15:0] sp_a, sp_b;
  logic we_a, we_b, irv_a, irv_b;
  logic [7:0] r1_a, r0_a, r1_b, r0_b;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_xfer_unit #(.START_ADDR(16'h03FF), .XFER_EN(1'b1), .DIR_FLAG_SEL(4), .SUPERVISOR(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .push(push), .pop(pop), .flags(flags), .ibit(ibit),
    .r1_in(r1_in), .r0_in(r0_in), .sp_out(sp_a), .rp_wr_en(we_a), .r1_out(r1_a),
    .r0_out(r0_a), .ibit_rst_val(irv_a));

  sp_xfer_unit #(.START_ADDR(16'h0100), .XFER_EN(1'b0), .DIR_FLAG_SEL(4), .SUPERVISOR(1'b0)) dut_fix_i (
    .clk(clk), .rst(rst), .cmd(cmd), .push(push), .pop(pop), .flags(flags), .ibit(ibit),
    .r1_in(r1_in), .r0_in(r0_in), .sp_out(sp_b), .rp_wr_en(we_b), .r1_out(r1_b),
    .r0_out(r0_b), .ibit_rst_val(irv_b));

  // {rst, cmd, push, pop, flags[8], ibit, {r1,r0}[16], exp_sp[16], exp_we}
  localparam logic [45:0] VECS [0:NVEC-1] = '{
    {4'b1000, 8'h00, 1'b0, 16'h0000, 16'h03FF, 1'b0},
    {4'b0010, 8'h00, 1'b0, 16'h0000, 16'h03FE, 1'b0},
    {4'b0001, 8'h00, 1'b0, 16'h0000, 16'h03FF, 1'b0},
    {4'b0011, 8'h00, 1'b0, 16'h0000, 16'h03FF, 1'b0},
    {4'b0100, 8'h10, 1'b1, 16'h1234, 16'h1234, 1'b0},
    {4'b0100, 8'hEF, 1'b1, 16'hFFFF, 16'h1234, 1'b1},
    {4'b0100, 8'h10, 1'b0, 16'hAAAA, 16'h1234, 1'b0},
    {4'b0100, 8'hEF, 1'b0, 16'hAAAA, 16'h1234, 1'b0},
    {4'b0100, 8'h10, 1'b1, 16'h0000, 16'h0000, 1'b0},
    {4'b0010, 8'h00, 1'b0, 16'h0000, 16'hFFFF, 1'b0},
    {4'b0001, 8'h00, 1'b0, 16'h0000, 16'h0000, 1'b0},
    {4'b0110, 8'h10, 1'b1, 16'h5678, 16'h5678, 1'b0},
    {4'b0101, 8'hEF, 1'b0, 16'h1111, 16'h5679, 1'b0},
    {4'b0100, 8'hEF, 1'b1, 16'h2222, 16'h5679, 1'b1},
    {4'b0100, 8'hFF, 1'b1, 16'hABCD, 16'hABCD, 1'b0},
    {4'b0101, 8'hEF, 1'b1, 16'h0000, 16'hABCD, 1'b1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1";   1, 9: return "R2";  2, 10: return "R3";  3: return "R4";
      4, 8: return "R6"; 5: return "R7";    6, 7, 12: return "R9";
      13, 14: return "R8"; default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic r, logic c, logic pu, logic po, logic [7:0] f, logic ib, logic [15:0] rp);
    @(negedge clk);
    rst = r; cmd = c; push = pu; pop = po; flags = f; ibit = ib; {r1_in, r0_in} = rp;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; cmd = 1'b0; push = 1'b0; pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; cmd = 1'b0; push = 1'b0; pop = 1'b0; flags = '0; ibit = 1'b0;
    r1_in = '0; r0_in = '0;
    repeat (2) @(posedge clk);

    check("R10", 32'(irv_a), 32'd1);
    check("R10", 32'(irv_b), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [45:0] v;
      v = VECS[i];
      apply(v[45], v[44], v[43], v[42], v[41:34], v[33], v[32:17]);
      check(vec_tag(i), 32'(sp_a), 32'(v[16:1]));
      check(vec_tag(i), 32'(we_a), 32'(v[0]));
      if (v[0]) check("R7", 32'({r1_a, r0_a}), 32'(v[16:1]));
    end

    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000);
    check("R7", 32'(we_a), 32'd0);

    apply(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0000);
    check("R1", 32'(sp_a), 32'h03FF);
    check("R1", 32'(sp_b), 32'h0100);
    check("R1", 32'(we_a), 32'd0);

    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0000);
    check("R2", 32'(sp_b), 32'h00FF);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 16'h1234);
    check("R5", 32'(sp_b), 32'h0100);
    check("R5", 32'(we_b), 32'd0);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 16'h0000);
    check("R3", 32'(sp_b), 32'h0101);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'hBEEF);
    check("R5", 32'(sp_b), 32'h0100);
    check("R5", 32'(we_b), 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule